// File: doc/BRIEF.md
# Pipeline Hazard and Operand Bypass Controller

This block is the hazard control for a five-stage in-order integer pipeline (fetch, decode, execute, memory, writeback). Each cycle it looks at the source register numbers of the instruction in decode and at the destination, write and load flags of the older instructions in execute and memory. From these it picks the bypass source for each ALU operand, freezes the front end when a value cannot arrive in time, and recovers from a wrong guess on a conditional branch.

The operand selects are worked out while the consumer is still in decode. They are registered, so they appear at the ports during the cycle that instruction spends in execute. Branches are guessed taken at fetch and resolved in execute. A branch that is found not taken squashes the two younger instructions and sends fetch to the fall-through path. The block also keeps a record of which stage slots hold bubbles or squashed work, so that stale register numbers in those slots can never cause a bypass or a stall. A bypass-disable input turns the block into a pure interlock for bring-up and test.

Top module: `pipe_hazard_ctrl`

## Requirements
- R1: Each operand select `fwd_a`/`fwd_b` is 2 bits: 00 register file, 01 memory/writeback register, 10 execute/memory register; 11 never appears. The select worked out for a decode instruction appears in the next cycle.
- R2: A decode source equal to the destination of a writing, non-load execute instruction gives select 10 in the next cycle, with no stall.
- R3: A decode source that matches only a writing memory-stage instruction gives select 01. When both the execute and memory destinations match, 10 wins.
- R4: A producer whose write flag is low never causes a bypass or a stall, even if it is a load.
- R5: Register 0 never causes a bypass or a stall.
- R6: A live load in execute whose destination matches a decode source raises `stall`, lowers `fe_ce` and raises `idex_nop` for exactly one cycle. In the next cycle there is no stall, and the cycle after that shows select 01 for that operand.
- R7: With `fwd_en` low, all selects are 00, and decode stalls while a matching writer sits in execute or memory. An adjacent dependence therefore costs two stall cycles.
- R8: A live branch in execute with `ex_taken` low raises `redirect`, `ifid_nop` and `idex_nop` in that cycle. With `ex_taken` high it raises none of them.
- R9: When a misprediction and a stall condition fall in the same cycle, the misprediction wins: `stall` low, `fe_ce` high, `redirect` high.
- R10: Slots that hold bubbles, squashed instructions or nothing at all after reset never source a bypass or a stall, whatever register fields are shown for them.
- R11: After reset: `stall` 0, `fe_ce` 1, both selects 00, `redirect` 0.
- R12: `fe_ce`, the clock enable for the PC and the fetch/decode register, is low in exactly the cycles in which `stall` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fwd_en | input | 1 | Bypass enable; when low, the block only interlocks |
| id_rs1 | input | AW | First source register of the decode instruction |
| id_rs2 | input | AW | Second source register of the decode instruction |
| ex_rd | input | AW | Destination register of the execute instruction |
| ex_we | input | 1 | Execute instruction writes a register |
| ex_is_load | input | 1 | Execute instruction is a load |
| ex_is_branch | input | 1 | Execute instruction is a conditional branch |
| ex_taken | input | 1 | Resolved branch outcome in execute |
| mem_rd | input | AW | Destination register of the memory-stage instruction |
| mem_we | input | 1 | Memory-stage instruction writes a register |
| fwd_a | output | 2 | Operand A bypass select for the execute instruction |
| fwd_b | output | 2 | Operand B bypass select for the execute instruction |
| stall | output | 1 | Decode is held this cycle |
| fe_ce | output | 1 | Clock enable for the PC and the fetch/decode register |
| idex_nop | output | 1 | Load a no-op into the decode/execute register |
| ifid_nop | output | 1 | Load a no-op into the fetch/decode register |
| redirect | output | 1 | Send fetch to the not-taken path |

## Verification
The stall condition and the branch misprediction can fall in the same cycle. The bench provokes this by holding a writer in memory that matches a decode source while bypassing is off, and at the same time showing a not-taken branch in execute. It judges the outcome by requiring redirect with no stall and an enabled fetch clock in that cycle. In the next cycle it shows a matching load in execute and checks that no stall appears, because both the decode and execute slots now hold squashed work.

// File: rtl/hzc_pkg.sv
package hzc_pkg;
  typedef enum logic [1:0] {
    FWD_RF = 2'b00,
    FWD_MW = 2'b01,
    FWD_XM = 2'b10
  } fwd_sel_e;
endpackage

// File: rtl/hzc_match.sv
// Dependence comparator: the source matches a live, writing producer
// whose destination is not the hardwired zero register.
module hzc_match #(
  parameter int AW = 5
) (
  input  logic [AW-1:0] src,
  input  logic [AW-1:0] dst,
  input  logic          wr,
  input  logic          live,
  output logic          hit
);
  always_comb begin
    hit = live && wr && (dst != '0) && (dst == src);
  end
endmodule

// File: rtl/hzc_fwd_sel.sv
// Per-operand bypass choice made in decode, registered into execute.
module hzc_fwd_sel
  import hzc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fwd_en,
  input  logic       clear,
  input  logic       hit_xm,
  input  logic       hit_mw,
  output logic [1:0] sel
);
  fwd_sel_e sel_d, sel_q;

  always_comb begin
    sel_d = FWD_RF;
    if (!clear && fwd_en) begin
      if (hit_xm)      sel_d = FWD_XM;
      else if (hit_mw) sel_d = FWD_MW;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= FWD_RF;
    else        sel_q <= sel_d;
  end

  assign sel = sel_q;
endmodule

// File: rtl/hzc_policy.sv
// Stall / squash policy: load-use and bypass-off interlocks, with the
// execute-stage misprediction overriding any stall.
module hzc_policy (
  input  logic fwd_en,
  input  logic ex_live,
  input  logic ex_hit_any,
  input  logic mem_hit_any,
  input  logic ex_is_load,
  input  logic ex_is_branch,
  input  logic ex_taken,
  output logic stall,
  output logic fe_ce,
  output logic idex_nop,
  output logic ifid_nop,
  output logic redirect
);
  logic mispredict, load_use, no_bypass, stall_req;

  always_comb begin
    mispredict = ex_live && ex_is_branch && !ex_taken;
    load_use   = ex_hit_any && ex_is_load;
    no_bypass  = !fwd_en && (ex_hit_any || mem_hit_any);
    stall_req  = load_use || no_bypass;
    stall      = stall_req && !mispredict;
    fe_ce      = !stall;
    idex_nop   = stall || mispredict;
    ifid_nop   = mispredict;
    redirect   = mispredict;
  end
endmodule

// File: rtl/hzc_slot_track.sv
// Tracks which stage slots carry dead work (bubble, squash, empty).
module hzc_slot_track (
  input  logic clk,
  input  logic rst_n,
  input  logic stall,
  input  logic flush,
  output logic id_live,
  output logic ex_live,
  output logic mem_live
);
  logic id_dead_q, ex_dead_q, mem_dead_q;
  logic id_dead_d, ex_dead_d, mem_dead_d;

  always_comb begin
    if (flush)      id_dead_d = 1'b1;
    else if (stall) id_dead_d = id_dead_q;
    else            id_dead_d = 1'b0;
    ex_dead_d  = stall || flush || id_dead_q;
    mem_dead_d = ex_dead_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      id_dead_q  <= 1'b1;
      ex_dead_q  <= 1'b1;
      mem_dead_q <= 1'b1;
    end else begin
      id_dead_q  <= id_dead_d;
      ex_dead_q  <= ex_dead_d;
      mem_dead_q <= mem_dead_d;
    end
  end

  assign id_live  = !id_dead_q;
  assign ex_live  = !ex_dead_q;
  assign mem_live = !mem_dead_q;
endmodule

// File: rtl/pipe_hazard_ctrl.sv
module pipe_hazard_ctrl #(
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fwd_en,
  input  logic [AW-1:0] id_rs1,
  input  logic [AW-1:0] id_rs2,
  input  logic [AW-1:0] ex_rd,
  input  logic          ex_we,
  input  logic          ex_is_load,
  input  logic          ex_is_branch,
  input  logic          ex_taken,
  input  logic [AW-1:0] mem_rd,
  input  logic          mem_we,
  output logic [1:0]    fwd_a,
  output logic [1:0]    fwd_b,
  output logic          stall,
  output logic          fe_ce,
  output logic          idex_nop,
  output logic          ifid_nop,
  output logic          redirect
);
  localparam int NSRC = 2;

  logic          id_live, ex_live, mem_live;
  logic          ex_pair_live, mem_pair_live, sel_clear;
  logic [AW-1:0] src [NSRC];
  logic [NSRC-1:0] hit_xm, hit_mw;
  logic [1:0]    sel [NSRC];

  assign src[0]        = id_rs1;
  assign src[1]        = id_rs2;
  assign ex_pair_live  = id_live && ex_live;
  assign mem_pair_live = id_live && mem_live;
  assign sel_clear     = idex_nop || !id_live;

  hzc_slot_track u_track (
    .clk      (clk),
    .rst_n    (rst_n),
    .stall    (stall),
    .flush    (redirect),
    .id_live  (id_live),
    .ex_live  (ex_live),
    .mem_live (mem_live)
  );

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    hzc_match #(.AW(AW)) u_m_xm (
      .src (src[i]), .dst (ex_rd), .wr (ex_we),
      .live(ex_pair_live), .hit (hit_xm[i])
    );
    hzc_match #(.AW(AW)) u_m_mw (
      .src (src[i]), .dst (mem_rd), .wr (mem_we),
      .live(mem_pair_live), .hit (hit_mw[i])
    );
    hzc_fwd_sel u_sel (
      .clk    (clk),
      .rst_n  (rst_n),
      .fwd_en (fwd_en),
      .clear  (sel_clear),
      .hit_xm (hit_xm[i]),
      .hit_mw (hit_mw[i]),
      .sel    (sel[i])
    );
  end

  hzc_policy u_policy (
    .fwd_en       (fwd_en),
    .ex_live      (ex_live),
    .ex_hit_any   (|hit_xm),
    .mem_hit_any  (|hit_mw),
    .ex_is_load   (ex_is_load),
    .ex_is_branch (ex_is_branch),
    .ex_taken     (ex_taken),
    .stall        (stall),
    .fe_ce        (fe_ce),
    .idex_nop     (idex_nop),
    .ifid_nop     (ifid_nop),
    .redirect     (redirect)
  );

  assign fwd_a = sel[0];
  assign fwd_b = sel[1];
endmodule

// File: rtl/hzc_chk.sv
module hzc_chk
  import hzc_pkg::*;
#(
  parameter int AW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          fwd_en,
  input logic [AW-1:0] id_rs1,
  input logic          ex_we,
  input logic          mem_we,
  input logic [1:0]    fwd_a,
  input logic [1:0]    fwd_b,
  input logic          stall,
  input logic          fe_ce,
  input logic          idex_nop,
  input logic          redirect
);
  logic armed_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= 1'b1;
  end

  AST_SEL_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_a != 2'b11) && (fwd_b != 2'b11)); // R1
  AST_FLUSH_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |-> (!stall && fe_ce)); // R9
  AST_LOADUSE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && $past(stall) && $past(fwd_en) && fwd_en) |-> !stall); // R6
  AST_ZERO_REG_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && ($past(id_rs1) == '0)) |-> (fwd_a == FWD_RF)); // R5
  AST_NOBYPASS_RF: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && !$past(fwd_en)) |-> (fwd_a == FWD_RF && fwd_b == FWD_RF)); // R7
  AST_BUBBLE_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && $past(idex_nop)) |-> (fwd_a == FWD_RF && fwd_b == FWD_RF)); // R10
  AST_STALL_HAS_WRITER: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (ex_we || mem_we)); // R4
endmodule

bind pipe_hazard_ctrl hzc_chk #(.AW(AW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .fwd_en   (fwd_en),
  .id_rs1   (id_rs1),
  .ex_we    (ex_we),
  .mem_we   (mem_we),
  .fwd_a    (fwd_a),
  .fwd_b    (fwd_b),
  .stall    (stall),
  .fe_ce    (fe_ce),
  .idex_nop (idex_nop),
  .redirect (redirect)
);

// File: tb/pipe_hazard_ctrl_tb.sv
module pipe_hazard_ctrl_tb;
  localparam int AW = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          fwd_en;
  logic [AW-1:0] id_rs1, id_rs2, ex_rd, mem_rd;
  logic          ex_we, ex_is_load, ex_is_branch, ex_taken, mem_we;
  logic [1:0]    fwd_a, fwd_b;
  logic          stall, fe_ce, idex_nop, ifid_nop, redirect;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  pipe_hazard_ctrl #(.AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .fwd_en(fwd_en),
    .id_rs1(id_rs1), .id_rs2(id_rs2),
    .ex_rd(ex_rd), .ex_we(ex_we), .ex_is_load(ex_is_load),
    .ex_is_branch(ex_is_branch), .ex_taken(ex_taken),
    .mem_rd(mem_rd), .mem_we(mem_we),
    .fwd_a(fwd_a), .fwd_b(fwd_b), .stall(stall), .fe_ce(fe_ce),
    .idex_nop(idex_nop), .ifid_nop(ifid_nop), .redirect(redirect)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clear_in();
    fwd_en = 1'b1; id_rs1 = '0; id_rs2 = '0; ex_rd = '0; mem_rd = '0;
    ex_we = 1'b0; ex_is_load = 1'b0; ex_is_branch = 1'b0;
    ex_taken = 1'b0; mem_we = 1'b0;
  endtask

  // Move to the next negative edge with idle inputs; caller then sets fields.
  task automatic next_cycle();
    @(negedge clk);
    clear_in();
  endtask

  task automatic settle();
    for (int k = 0; k < 3; k++) next_cycle();
  endtask

  task automatic t_reset();
    // first cycle after release: all slots empty
    next_cycle();
    ex_rd = 5'd3; ex_we = 1'b1; ex_is_load = 1'b1; id_rs1 = 5'd3; #1;
    chk("R11 stall after reset", stall, 0);
    chk("R11 fe_ce after reset", fe_ce, 1);
    chk("R11 fwd_a after reset", fwd_a, 0);
    chk("R11 redirect after reset", redirect, 0);
    chk("R10 empty slot no stall", stall, 0);
  endtask

  task automatic t_ex_bypass();
    settle();
    next_cycle(); id_rs1 = 5'd5; ex_rd = 5'd5; ex_we = 1'b1; #1;
    chk("R2 no stall on ALU dep", stall, 0);
    next_cycle(); #1;
    chk("R2 fwd_a from ex/mem", fwd_a, 2);
    chk("R1 fwd_b untouched", fwd_b, 0);
  endtask

  task automatic t_mem_bypass();
    settle();
    next_cycle(); id_rs2 = 5'd7; mem_rd = 5'd7; mem_we = 1'b1; #1;
    chk("R3 no stall on mem dep", stall, 0);
    next_cycle(); id_rs1 = 5'd9; ex_rd = 5'd9; ex_we = 1'b1;
    mem_rd = 5'd9; mem_we = 1'b1; #1;
    chk("R3 fwd_b from mem/wb", fwd_b, 1);
    next_cycle(); #1;
    chk("R3 ex/mem wins over mem/wb", fwd_a, 2);
  endtask

  task automatic t_we_low();
    settle();
    next_cycle(); id_rs1 = 5'd4; ex_rd = 5'd4; ex_is_load = 1'b1; #1;
    chk("R4 no stall without write", stall, 0);
    next_cycle(); #1;
    chk("R4 no bypass without write", fwd_a, 0);
  endtask

  task automatic t_reg_zero();
    settle();
    next_cycle(); id_rs1 = '0; ex_rd = '0; ex_we = 1'b1; ex_is_load = 1'b1;
    id_rs2 = '0; mem_rd = '0; mem_we = 1'b1; #1;
    chk("R5 r0 no stall", stall, 0);
    next_cycle(); #1;
    chk("R5 r0 no bypass a", fwd_a, 0);
    chk("R5 r0 no bypass b", fwd_b, 0);
  endtask

  task automatic t_load_use();
    settle();
    next_cycle(); id_rs1 = 5'd3; ex_rd = 5'd3; ex_we = 1'b1; ex_is_load = 1'b1; #1;
    chk("R6 load-use stall", stall, 1);
    chk("R12 fe_ce low on stall", fe_ce, 0);
    chk("R6 bubble into id/ex", idex_nop, 1);
    // load now in memory; execute holds the bubble with stale fields
    next_cycle(); id_rs1 = 5'd3; ex_rd = 5'd3; ex_we = 1'b1; ex_is_load = 1'b1;
    mem_rd = 5'd3; mem_we = 1'b1; #1;
    chk("R6 single stall cycle", stall, 0);
    chk("R12 fe_ce high without stall", fe_ce, 1);
    next_cycle(); #1;
    chk("R6 load value from mem/wb", fwd_a, 1);
  endtask

  task automatic t_no_bypass();
    settle();
    next_cycle(); fwd_en = 1'b0; id_rs2 = 5'd6; ex_rd = 5'd6; ex_we = 1'b1; #1;
    chk("R7 stall cycle 1", stall, 1);
    next_cycle(); fwd_en = 1'b0; id_rs2 = 5'd6; mem_rd = 5'd6; mem_we = 1'b1; #1;
    chk("R7 stall cycle 2", stall, 1);
    chk("R7 selects stay rf", fwd_b, 0);
    next_cycle(); fwd_en = 1'b0; id_rs2 = 5'd6; mem_rd = 5'd6; mem_we = 1'b1; #1;
    chk("R7 released after two", stall, 0);
    next_cycle(); #1;
    chk("R7 read from register file", fwd_b, 0);
  endtask

  task automatic t_branch();
    settle();
    next_cycle(); ex_is_branch = 1'b1; ex_taken = 1'b1; #1;
    chk("R8 taken no redirect", redirect, 0);
    chk("R8 taken no squash", ifid_nop, 0);
    next_cycle(); ex_is_branch = 1'b1; ex_taken = 1'b0; #1;
    chk("R8 not-taken redirect", redirect, 1);
    chk("R8 squash if/id", ifid_nop, 1);
    chk("R8 squash id/ex", idex_nop, 1);
  endtask

  task automatic t_flush_vs_stall();
    settle();
    next_cycle(); fwd_en = 1'b0; id_rs1 = 5'd2; mem_rd = 5'd2; mem_we = 1'b1;
    ex_is_branch = 1'b1; ex_taken = 1'b0; #1;
    chk("R9 flush beats stall", stall, 0);
    chk("R9 fetch clock on", fe_ce, 1);
    chk("R9 redirect", redirect, 1);
    next_cycle(); id_rs1 = 5'd8; ex_rd = 5'd8; ex_we = 1'b1; ex_is_load = 1'b1; #1;
    chk("R10 squashed slots no stall", stall, 0);
    next_cycle(); #1;
    chk("R10 squashed slot no bypass", fwd_a, 0);
  endtask

  initial begin
    clear_in();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_ex_bypass();
    t_mem_bypass();
    t_we_low();
    t_reg_zero();
    t_load_use();
    t_no_bypass();
    t_branch();
    t_flush_vs_stall();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_vec++;
      n_bad++;
      $display("FAIL watchdog (all R) actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule